// File: doc/BRIEF.md
# DS3 Maintenance Error Counters

This block collects the error strobes that a DS3 receiver's framer and line decoder raise and turns them into counts that a host reads over a byte-wide register port. Single-cycle strobes feed the framing-bit, P-parity, path (C-parity) and line-code counters. At the end of each M-frame, a frame strobe carries the two X bits, the two P bits and the three subframe-4 C-bits. The block uses them to count X disagreements, P disagreements and far-end block errors.

Every counter is cleared when it is read. Every counter stops at full scale instead of wrapping around. Reaching full scale sets a sticky interrupt source. The seven sources, each with its own enable bit, are combined into one interrupt output. A sticky copy of five live alarm inputs keeps any alarm that was only briefly present until the host reads it.

Top module: `ds3_err_acc`

## Requirements
- R1: The framing-bit, P-parity and path counters are 8 bits wide. Each adds one for every clock cycle in which its strobe is high, and each holds at 255 instead of wrapping.
- R2: Address 7 reads a disagreement byte. Bits 3:0 count M-frames whose two X bits differ, and bits 7:4 count M-frames whose two P bits differ. Each nibble holds at 15. The bits are looked at only in a cycle where `mf_done_i` is high.
- R3: The FEBE counter (address 6) adds one per M-frame in which any of the three subframe-4 C-bits is 0.
- R4: The line-code counter is 16 bits wide. Reading the low byte (address 8) returns bits 7:0 and captures bits 15:8 at the same moment. Reading address 9 returns that captured byte without clearing anything. The counter holds at 65535.
- R5: Reading any counter returns its value and clears it. A strobe that arrives in the same cycle as the read counts as 1 in the new period.
- R6: Interrupt status (address 2) has one bit per counter: bit 0 framing, 1 P-parity, 2 path, 3 FEBE, 4 X-disagree, 5 P-disagree, 6 line-code. A bit is set when its counter reaches full scale. It stays set until address 2 is read, and reading address 2 clears it.
- R7: `cnt_irq_o` is high exactly when some interrupt status bit is set while its `irq_en_i` bit is also set.
- R8: Address 1 holds a sticky copy of `alarm_i`. Reading it returns the copy and clears it, but any alarm still present in the read cycle is latched again. Address 0 returns the live `alarm_i`.
- R9: `rd_data_o` shows the selected register one cycle after a read is requested, and unmapped addresses return 0. After reset, every register reads 0 and `cnt_irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_err_i | input | 1 | Framing-bit error strobe |
| lcv_i | input | 1 | Line code violation strobe |
| ppar_err_i | input | 1 | P-bit parity error strobe |
| path_err_i | input | 1 | C-bit parity (path) error strobe |
| mf_done_i | input | 1 | End-of-M-frame strobe qualifying the bit inputs |
| xbits_i | input | 2 | The M-frame's two X bits |
| pbits_i | input | 2 | The M-frame's two P bits |
| sf4_c_i | input | 3 | The M-frame's subframe-4 C-bits |
| alarm_i | input | 5 | Live maintenance status |
| irq_en_i | input | 7 | Per-source interrupt enables |
| rd_en_i | input | 1 | Read request |
| rd_addr_i | input | 4 | Read address |
| rd_data_o | output | 8 | Registered read data |
| cnt_irq_o | output | 1 | Combined counter interrupt |

## Verification
A strobe that is high at a clock edge has been counted by that edge. A read that is requested at an edge shows its data after that same edge, which makes the value visible one cycle later. The bench therefore drives every input on the falling edge and reads `rd_data_o` on the next falling edge. The clear, the recapture of an alarm still present, and the restart at 1 caused by a strobe in the read cycle all happen at the read edge. The bench checks each of them with a second read. `cnt_irq_o` is a combination of registered bits, so the bench checks it half a cycle after the enables change.

// File: rtl/ds3_err_pkg.sv
package ds3_err_pkg;
   localparam int NSRC = 7;
   localparam logic [3:0] A_LIVE = 4'd0;
   localparam logic [3:0] A_SHD  = 4'd1;
   localparam logic [3:0] A_IRQ  = 4'd2;
   localparam logic [3:0] A_FRM  = 4'd3;  // A_FRM..A_FEBE consecutive
   localparam logic [3:0] A_DIS  = 4'd7;
   localparam logic [3:0] A_LCVL = 4'd8;
   localparam logic [3:0] A_LCVH = 4'd9;
   localparam int IB_XDIS = 4;
   localparam int IB_PDIS = 5;
   localparam int IB_LCV  = 6;
endpackage

// File: rtl/ds3_sat_ctr.sv
module ds3_sat_ctr #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc_i,
   input  logic         clr_i,
   output logic [W-1:0] cnt_o,
   output logic         full_hit_o
);
   localparam logic [W-1:0] MAXV = '1;

   if (W < 2) begin : g_bad_w
      $error("ds3_sat_ctr: W must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                     cnt_o <= '0;
      else if (clr_i)                 cnt_o <= {{(W-1){1'b0}}, inc_i};
      else if (inc_i && cnt_o != MAXV) cnt_o <= cnt_o + 1'b1;
   end

   assign full_hit_o = inc_i && !clr_i && (cnt_o == MAXV - 1'b1);

   // R1
   sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_o == MAXV && !clr_i) |=> cnt_o == MAXV);
   // R5
   clr_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> cnt_o <= 1);
endmodule

// File: rtl/ds3_shadow_latch.sv
module ds3_shadow_latch #(
   parameter int N = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] live_i,
   input  logic         clr_i,
   output logic [N-1:0] shadow_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) shadow_o <= '0;
      else        shadow_o <= (clr_i ? '0 : shadow_o) | live_i;
   end

   // R8
   shadow_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (shadow_o & $past(live_i)) == $past(live_i));
endmodule

// File: rtl/ds3_err_acc.sv
module ds3_err_acc
   import ds3_err_pkg::*;
#(
   parameter int CW  = 8,
   parameter int DW  = 4,
   parameter int LW  = 16,
   parameter int NST = 5
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           frm_err_i,
   input  logic           lcv_i,
   input  logic           ppar_err_i,
   input  logic           path_err_i,
   input  logic           mf_done_i,
   input  logic [1:0]     xbits_i,
   input  logic [1:0]     pbits_i,
   input  logic [2:0]     sf4_c_i,
   input  logic [NST-1:0] alarm_i,
   input  logic [NSRC-1:0] irq_en_i,
   input  logic           rd_en_i,
   input  logic [3:0]     rd_addr_i,
   output logic [CW-1:0]  rd_data_o,
   output logic           cnt_irq_o
);
   localparam int NB = 4;

   if (2 * DW != CW) begin : g_bad_dw
      $error("ds3_err_acc: two disagreement nibbles must fill one byte");
   end
   if (2 * CW != LW) begin : g_bad_lw
      $error("ds3_err_acc: line-code counter must be two bytes");
   end
   if (NST > CW) begin : g_bad_nst
      $error("ds3_err_acc: status wider than the read port");
   end

   logic [NB-1:0]   b_ev, b_hit;
   logic [CW-1:0]   b_cnt [NB];
   logic [DW-1:0]   xd_cnt, pd_cnt;
   logic            xd_hit, pd_hit, lcv_hit;
   logic [LW-1:0]   lcv_cnt;
   logic [CW-1:0]   lcv_hi_snap;
   logic [NST-1:0]  shadow;
   logic [NSRC-1:0] irq_stat, irq_set;
   logic [CW-1:0]   rd_mux;

   wire rd_dis  = rd_en_i && rd_addr_i == A_DIS;
   wire rd_lcvl = rd_en_i && rd_addr_i == A_LCVL;
   wire rd_irq  = rd_en_i && rd_addr_i == A_IRQ;
   wire rd_shd  = rd_en_i && rd_addr_i == A_SHD;

   assign b_ev = {mf_done_i && !(&sf4_c_i), path_err_i, ppar_err_i, frm_err_i};

   for (genvar i = 0; i < NB; i++) begin : g_byte
      localparam logic [3:0] MY_ADDR = A_FRM + 4'(i);
      ds3_sat_ctr #(.W(CW)) u_ctr (
         .clk(clk), .rst_n(rst_n), .inc_i(b_ev[i]),
         .clr_i(rd_en_i && rd_addr_i == MY_ADDR),
         .cnt_o(b_cnt[i]), .full_hit_o(b_hit[i]));
   end

   ds3_sat_ctr #(.W(DW)) u_xdis (
      .clk(clk), .rst_n(rst_n), .inc_i(mf_done_i && (xbits_i[0] ^ xbits_i[1])),
      .clr_i(rd_dis), .cnt_o(xd_cnt), .full_hit_o(xd_hit));
   ds3_sat_ctr #(.W(DW)) u_pdis (
      .clk(clk), .rst_n(rst_n), .inc_i(mf_done_i && (pbits_i[0] ^ pbits_i[1])),
      .clr_i(rd_dis), .cnt_o(pd_cnt), .full_hit_o(pd_hit));
   ds3_sat_ctr #(.W(LW)) u_lcv (
      .clk(clk), .rst_n(rst_n), .inc_i(lcv_i),
      .clr_i(rd_lcvl), .cnt_o(lcv_cnt), .full_hit_o(lcv_hit));

   ds3_shadow_latch #(.N(NST)) u_shd (
      .clk(clk), .rst_n(rst_n), .live_i(alarm_i), .clr_i(rd_shd), .shadow_o(shadow));

   always_ff @(posedge clk) begin
      if (!rst_n)       lcv_hi_snap <= '0;
      else if (rd_lcvl) lcv_hi_snap <= lcv_cnt[LW-1:CW];
   end

   always_comb begin
      irq_set = '0;
      irq_set[NB-1:0]  = b_hit;
      irq_set[IB_XDIS] = xd_hit;
      irq_set[IB_PDIS] = pd_hit;
      irq_set[IB_LCV]  = lcv_hit;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) irq_stat <= '0;
      else        irq_stat <= (rd_irq ? '0 : irq_stat) | irq_set;
   end

   assign cnt_irq_o = |(irq_stat & irq_en_i);

   always_comb begin
      rd_mux = '0;
      case (rd_addr_i)
         A_LIVE:  rd_mux = CW'(alarm_i);
         A_SHD:   rd_mux = CW'(shadow);
         A_IRQ:   rd_mux = CW'(irq_stat);
         A_DIS:   rd_mux = {pd_cnt, xd_cnt};
         A_LCVL:  rd_mux = lcv_cnt[CW-1:0];
         A_LCVH:  rd_mux = lcv_hi_snap;
         default: begin
            for (int i = 0; i < NB; i++)
               if (rd_addr_i == A_FRM + 4'(i)) rd_mux = b_cnt[i];
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       rd_data_o <= '0;
      else if (rd_en_i) rd_data_o <= rd_mux;
   end

   // R6
   irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_irq |=> (irq_stat & $past(irq_stat)) == $past(irq_stat));
   // R7
   irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_stat == '0) |-> !cnt_irq_o);
   // R4
   lcv_snap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_lcvl |=> $stable(lcv_hi_snap));
endmodule

// File: tb/sim_ds3_err_acc.sv
`timescale 1ns/1ps
module sim_ds3_err_acc;
   logic clk = 0, rst_n = 0;
   logic frm = 0, lcv = 0, ppar = 0, path = 0, mf = 0;
   logic [1:0] xb = 0, pb = 0;
   logic [2:0] c4 = 3'b111;
   logic [4:0] alarm = 0;
   logic [6:0] ien = 0;
   logic rd_en = 0;
   logic [3:0] addr = 0;
   logic [7:0] rdata;
   logic irq;
   int n_run = 0, n_fail = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   ds3_err_acc u0 (
      .clk(clk), .rst_n(rst_n), .frm_err_i(frm), .lcv_i(lcv), .ppar_err_i(ppar),
      .path_err_i(path), .mf_done_i(mf), .xbits_i(xb), .pbits_i(pb), .sf4_c_i(c4),
      .alarm_i(alarm), .irq_en_i(ien), .rd_en_i(rd_en), .rd_addr_i(addr),
      .rd_data_o(rdata), .cnt_irq_o(irq));

   task automatic chk(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] v);
      @(negedge clk); rd_en = 1; addr = a;
      @(negedge clk); rd_en = 0; v = rdata;
   endtask

   task automatic rdchk(input string req, input logic [3:0] a, input int exp);
      logic [7:0] v;
      rd(a, v);
      chk(req, v, exp);
   endtask

   task automatic pulse(ref logic s, input int n);
      if (n == 0) return;
      @(negedge clk); s = 1;
      repeat (n) @(negedge clk);
      s = 0;
   endtask

   task automatic mframe(input logic [1:0] x, input logic [1:0] p, input logic [2:0] c);
      @(negedge clk); mf = 1; xb = x; pb = p; c4 = c;
      @(negedge clk); mf = 0; xb = 0; pb = 0; c4 = 3'b111;
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R9 reset state
      for (int a = 0; a < 16; a++) rdchk("R9 reset", 4'(a), 0);
      chk("R9 irq reset", irq, 0);
      // R1 sweep of path counter, R5 clear each time
      for (int n = 0; n < 10; n++) begin
         pulse(path, n);
         rdchk("R1 path count", 4'd5, n);
      end
      rdchk("R5 cleared", 4'd5, 0);
      pulse(ppar, 7);
      rdchk("R1 ppar count", 4'd4, 7);
      // R5 event in read cycle goes to the new period
      pulse(frm, 4);
      @(negedge clk); rd_en = 1; addr = 4'd3; frm = 1;
      @(negedge clk); rd_en = 0; frm = 0;
      chk("R5 read returns old", rdata, 4);
      rdchk("R5 new period", 4'd3, 1);
      // R1 saturation, R6 set, R7 gating
      pulse(frm, 300);
      ien = 7'h02; @(negedge clk);
      chk("R7 masked", irq, 0);
      ien = 7'h01; @(negedge clk);
      chk("R7 enabled", irq, 1);
      rdchk("R1 frm saturates", 4'd3, 255);
      chk("R6 sticky after counter read", irq, 1);
      rdchk("R6 irq status", 4'd2, 8'h01);
      rdchk("R6 irq cleared", 4'd2, 0);
      chk("R7 low after clear", irq, 0);
      ien = 0;
      // R2 disagreement
      repeat (3) mframe(2'b01, 2'b00, 3'b111);
      repeat (5) mframe(2'b11, 2'b10, 3'b111);
      repeat (2) mframe(2'b00, 2'b11, 3'b111);
      @(negedge clk); xb = 2'b01; pb = 2'b10;
      @(negedge clk); xb = 0; pb = 0;
      rdchk("R2 nibbles", 4'd7, 8'h53);
      repeat (20) mframe(2'b10, 2'b01, 3'b111);
      rdchk("R2 saturate", 4'd7, 8'hFF);
      rdchk("R6 disagree irq bits", 4'd2, 8'h30);
      // R3 FEBE
      mframe(0, 0, 3'b111); mframe(0, 0, 3'b101); mframe(0, 0, 3'b000);
      mframe(0, 0, 3'b110); mframe(0, 0, 3'b111);
      @(negedge clk); c4 = 3'b000;
      @(negedge clk); c4 = 3'b111;
      rdchk("R3 febe", 4'd6, 3);
      // R4 line-code counter
      pulse(lcv, 300);
      rdchk("R4 low byte", 4'd8, 8'h2C);
      pulse(lcv, 7);
      rdchk("R4 high snapshot", 4'd9, 8'h01);
      rdchk("R4 low after clear", 4'd8, 7);
      rdchk("R4 high zero", 4'd9, 0);
      pulse(lcv, 65540);
      rdchk("R4 low sat", 4'd8, 8'hFF);
      rdchk("R4 high sat", 4'd9, 8'hFF);
      rdchk("R6 lcv irq", 4'd2, 8'h40);
      // R8 shadow
      @(negedge clk); alarm = 5'b00100;
      @(negedge clk); alarm = 0;
      rdchk("R8 live", 4'd0, 0);
      rdchk("R8 shadow", 4'd1, 8'h04);
      rdchk("R8 shadow cleared", 4'd1, 0);
      @(negedge clk); alarm = 5'b10001;
      rdchk("R8 live held", 4'd0, 8'h11);
      rdchk("R8 shadow held", 4'd1, 8'h11);
      rdchk("R8 recaptured", 4'd1, 8'h11);
      alarm = 0;
      rdchk("R8 recapture ends", 4'd1, 8'h11);
      rdchk("R8 empty", 4'd1, 0);
      rdchk("R9 unmapped", 4'd12, 0);
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule